// File: doc/BRIEF.md
# Interrupt context save and restore sequencer

This block performs the multi-cycle register save and register restore work that surrounds interrupt handlers in a small 8-bit processor with two interrupt tiers. A request carries one of four operations, together with the current program counter, status byte, direct-page register, accumulator, two index registers and stack pointer. The block then walks a byte-wide stack in page one, one byte per clock, and returns the updated register set with a one-cycle done strobe. Interrupt arbitration, vector fetch and instruction fetch belong to the surrounding core.

Low-priority handlers get a full automatic context. On entry, five registers (six bytes) are pushed, the working registers are cleared and the mask flag is set. The matching return unwinds the same six bytes. The fast handlers (the maskable and non-maskable tiers) use a short prologue instead. It pushes A, X and Y, then parks the direct-page register in X. This frees the handler from any further use of the page-one stack. The epilogue moves the parked value back into D and pops the three bytes.

The request side is a valid/ready handshake. A request is taken only on a clock edge where both `req_valid` and `req_ready` are high, and the register inputs are sampled on that edge alone. `req_ready` stays low for the whole run of stack accesses. Anything presented on the request pins during that time is not taken and has no effect. It is considered again only once ready returns, which happens in the done cycle. The memory port has no back-pressure: the stack memory must complete a write or a combinational read in every cycle in which the block strobes it.

Top module: `irq_ctx_sequencer`

## Requirements
- R1: `req_ready` is high whenever no stack run is in progress (idle and done cycles). A request is accepted on an edge with `req_valid` and `req_ready` both high, and `req_op` selects the operation: 0 = low-priority entry, 1 = low-priority return, 2 = fast prologue, 3 = fast epilogue. The register inputs are sampled only at acceptance. While a run is in progress, `req_ready` is low and request pins are ignored.
- R2: Every stack access addresses 0x0100 + S. A push writes at 0x0100 + S and then decrements S. A pop first increments S and then reads at the new 0x0100 + S.
- R3: Low-priority entry writes six bytes in this order: PC high, PC low, P, D, A, Y. The P byte written is the input P, before the mask flag is set.
- R4: After a low-priority entry, A, Y and D are 0, P equals input P with bit 5 (mask flag) set, X and PC equal their inputs, and S equals input S minus 6.
- R5: A low-priority return reads six bytes into Y, A, D, P, PC low and PC high, in that order. S ends at input S plus 6, and X equals its input.
- R6: The fast prologue writes A, then X, then Y. It then leaves X equal to input D; A, Y and D are 0; P and PC are unchanged; and S equals input S minus 3.
- R7: The fast epilogue sets D to input X, then reads three bytes into Y, X and A in that order. S ends at input S plus 3, and P and PC are unchanged.
- R8: Stack accesses occur one byte per clock, starting in the cycle after acceptance. `done` is high for exactly one cycle, the cycle after the last access, and the output registers hold the final values in that cycle.
- R9: While reset is asserted, all register outputs are 0, `done`, `mem_we` and `mem_re` are 0, and `req_ready` is 1.
- R10: S wraps modulo 256, so runs that cross 0x00 or 0xFF stay within page one (0x0100 to 0x01FF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request presented |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | Operation code (see R1) |
| in_pc | input | 16 | Program counter at request |
| in_p | input | 8 | Status byte at request |
| in_d | input | 8 | Direct-page register at request |
| in_a | input | 8 | Accumulator at request |
| in_x | input | 8 | X index at request |
| in_y | input | 8 | Y index at request |
| in_s | input | 8 | Stack pointer at request |
| mem_we | output | 1 | Stack byte write strobe |
| mem_re | output | 1 | Stack byte read strobe |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the same cycle as the address |
| done | output | 1 | One-cycle completion strobe |
| out_pc | output | 16 | Updated program counter |
| out_p | output | 8 | Updated status byte |
| out_d | output | 8 | Updated direct-page register |
| out_a | output | 8 | Updated accumulator |
| out_x | output | 8 | Updated X index |
| out_y | output | 8 | Updated Y index |
| out_s | output | 8 | Updated stack pointer |

## Verification
Each operation is paired with its inverse, and the bench confirms that the pair restores the original register set. A design that swapped the pop order, or the PC byte order, would therefore return scrambled registers. An entry with S near zero checks wrap-around within page one. A design that carried into the page byte would write to page zero or page two. A design that saved P after setting the mask flag would return with interrupts masked, and this is caught by checking the saved P byte on the write bus. A request held high through a whole run tests back-pressure: a design that accepted it would restart and show extra stack accesses, or a second done strobe, after the first completion.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
  typedef enum logic [1:0] {
    OP_LOW_ENTER    = 2'd0,
    OP_LOW_RETURN   = 2'd1,
    OP_FAST_SAVE    = 2'd2,
    OP_FAST_RESTORE = 2'd3
  } ctx_op_e;

  typedef enum logic [2:0] {
    SEL_PCH, SEL_PCL, SEL_P, SEL_D, SEL_A, SEL_X, SEL_Y
  } ctx_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_RUN, ST_FIN
  } ctx_state_e;
endpackage

// File: rtl/ctx_step_decode.sv
module ctx_step_decode
  import ctx_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  ctx_op_e           op,
  input  logic [STEP_W-1:0] step,
  output ctx_sel_e          sel,
  output logic              push,
  output logic              last
);
  localparam int LONG_LAST  = 5;
  localparam int SHORT_LAST = 2;

  always_comb begin
    sel  = SEL_A;
    push = 1'b0;
    last = 1'b0;
    unique case (op)
      OP_LOW_ENTER: begin
        push = 1'b1;
        last = (step == STEP_W'(LONG_LAST));
        case (step)
          3'd0:    sel = SEL_PCH;
          3'd1:    sel = SEL_PCL;
          3'd2:    sel = SEL_P;
          3'd3:    sel = SEL_D;
          3'd4:    sel = SEL_A;
          default: sel = SEL_Y;
        endcase
      end
      OP_LOW_RETURN: begin
        last = (step == STEP_W'(LONG_LAST));
        case (step)
          3'd0:    sel = SEL_Y;
          3'd1:    sel = SEL_A;
          3'd2:    sel = SEL_D;
          3'd3:    sel = SEL_P;
          3'd4:    sel = SEL_PCL;
          default: sel = SEL_PCH;
        endcase
      end
      OP_FAST_SAVE: begin
        push = 1'b1;
        last = (step == STEP_W'(SHORT_LAST));
        case (step)
          3'd0:    sel = SEL_A;
          3'd1:    sel = SEL_X;
          default: sel = SEL_Y;
        endcase
      end
      default: begin
        last = (step == STEP_W'(SHORT_LAST));
        case (step)
          3'd0:    sel = SEL_Y;
          3'd1:    sel = SEL_X;
          default: sel = SEL_A;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/ctx_stack_port.sv
module ctx_stack_port
  import ctx_seq_pkg::*;
#(
  parameter int              REG_W      = 8,
  parameter logic [REG_W-1:0] STACK_PAGE = 8'h01
) (
  input  logic               active,
  input  logic               push,
  input  ctx_sel_e           sel,
  input  logic [REG_W-1:0]   s,
  input  logic [2*REG_W-1:0] pc,
  input  logic [REG_W-1:0]   p,
  input  logic [REG_W-1:0]   d,
  input  logic [REG_W-1:0]   a,
  input  logic [REG_W-1:0]   x,
  input  logic [REG_W-1:0]   y,
  output logic               we,
  output logic               re,
  output logic [2*REG_W-1:0] addr,
  output logic [REG_W-1:0]   wdata
);
  logic [REG_W-1:0] slot;

  assign slot = push ? s : s + 1'b1;
  assign addr = {STACK_PAGE, slot};
  assign we   = active & push;
  assign re   = active & ~push;

  always_comb begin
    unique case (sel)
      SEL_PCH: wdata = pc[2*REG_W-1:REG_W];
      SEL_PCL: wdata = pc[REG_W-1:0];
      SEL_P:   wdata = p;
      SEL_D:   wdata = d;
      SEL_A:   wdata = a;
      SEL_X:   wdata = x;
      default: wdata = y;
    endcase
  end
endmodule

// File: rtl/ctx_finish.sv
module ctx_finish
  import ctx_seq_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int MFLAG_BIT = 5
) (
  input  ctx_op_e          op,
  input  logic [REG_W-1:0] p_in,
  input  logic [REG_W-1:0] d_in,
  input  logic [REG_W-1:0] a_in,
  input  logic [REG_W-1:0] x_in,
  input  logic [REG_W-1:0] y_in,
  output logic [REG_W-1:0] p_out,
  output logic [REG_W-1:0] d_out,
  output logic [REG_W-1:0] a_out,
  output logic [REG_W-1:0] x_out,
  output logic [REG_W-1:0] y_out
);
  localparam logic [REG_W-1:0] MASK_ONE = REG_W'(1) << MFLAG_BIT;

  always_comb begin
    p_out = p_in;
    d_out = d_in;
    a_out = a_in;
    x_out = x_in;
    y_out = y_in;
    if (op == OP_LOW_ENTER) begin
      p_out = p_in | MASK_ONE;
      d_out = '0;
      a_out = '0;
      y_out = '0;
    end else if (op == OP_FAST_SAVE) begin
      x_out = d_in;
      d_out = '0;
      a_out = '0;
      y_out = '0;
    end
  end
endmodule

// File: rtl/irq_ctx_sequencer.sv
module irq_ctx_sequencer
  import ctx_seq_pkg::*;
#(
  parameter int               REG_W      = 8,
  parameter int               MFLAG_BIT  = 5,
  parameter logic [REG_W-1:0] STACK_PAGE = 8'h01,
  parameter int               STEP_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [2*REG_W-1:0] in_pc,
  input  logic [REG_W-1:0]   in_p,
  input  logic [REG_W-1:0]   in_d,
  input  logic [REG_W-1:0]   in_a,
  input  logic [REG_W-1:0]   in_x,
  input  logic [REG_W-1:0]   in_y,
  input  logic [REG_W-1:0]   in_s,
  output logic               mem_we,
  output logic               mem_re,
  output logic [2*REG_W-1:0] mem_addr,
  output logic [REG_W-1:0]   mem_wdata,
  input  logic [REG_W-1:0]   mem_rdata,
  output logic               done,
  output logic [2*REG_W-1:0] out_pc,
  output logic [REG_W-1:0]   out_p,
  output logic [REG_W-1:0]   out_d,
  output logic [REG_W-1:0]   out_a,
  output logic [REG_W-1:0]   out_x,
  output logic [REG_W-1:0]   out_y,
  output logic [REG_W-1:0]   out_s
);
  localparam int PC_W = 2 * REG_W;

  ctx_state_e        state_q;
  ctx_op_e           op_q;
  logic [STEP_W-1:0] step_q;
  logic [PC_W-1:0]   pc_q;
  logic [REG_W-1:0]  p_q, d_q, a_q, x_q, y_q, s_q;

  ctx_sel_e          dec_sel;
  logic              dec_push, dec_last;
  logic [REG_W-1:0]  fin_p, fin_d, fin_a, fin_x, fin_y;
  logic              accept;

  assign req_ready = (state_q != ST_RUN);
  assign accept    = req_valid & req_ready;
  assign done      = (state_q == ST_FIN);

  ctx_step_decode #(.STEP_W(STEP_W)) u_decode (
    .op(op_q), .step(step_q), .sel(dec_sel), .push(dec_push), .last(dec_last)
  );

  ctx_stack_port #(.REG_W(REG_W), .STACK_PAGE(STACK_PAGE)) u_port (
    .active(state_q == ST_RUN), .push(dec_push), .sel(dec_sel), .s(s_q),
    .pc(pc_q), .p(p_q), .d(d_q), .a(a_q), .x(x_q), .y(y_q),
    .we(mem_we), .re(mem_re), .addr(mem_addr), .wdata(mem_wdata)
  );

  ctx_finish #(.REG_W(REG_W), .MFLAG_BIT(MFLAG_BIT)) u_finish (
    .op(op_q), .p_in(p_q), .d_in(d_q), .a_in(a_q), .x_in(x_q), .y_in(y_q),
    .p_out(fin_p), .d_out(fin_d), .a_out(fin_a), .x_out(fin_x), .y_out(fin_y)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_LOW_ENTER;
      step_q  <= '0;
      pc_q    <= '0;
      p_q     <= '0;
      d_q     <= '0;
      a_q     <= '0;
      x_q     <= '0;
      y_q     <= '0;
      s_q     <= '0;
    end else if (accept) begin
      state_q <= ST_RUN;
      op_q    <= ctx_op_e'(req_op);
      step_q  <= '0;
      pc_q    <= in_pc;
      p_q     <= in_p;
      a_q     <= in_a;
      x_q     <= in_x;
      y_q     <= in_y;
      s_q     <= in_s;
      // the epilogue restores D from the parked copy before popping X
      d_q     <= (ctx_op_e'(req_op) == OP_FAST_RESTORE) ? in_x : in_d;
    end else if (state_q == ST_RUN) begin
      s_q <= dec_push ? s_q - 1'b1 : s_q + 1'b1;
      if (!dec_push) begin
        unique case (dec_sel)
          SEL_PCH: pc_q[PC_W-1:REG_W] <= mem_rdata;
          SEL_PCL: pc_q[REG_W-1:0]    <= mem_rdata;
          SEL_P:   p_q <= mem_rdata;
          SEL_D:   d_q <= mem_rdata;
          SEL_A:   a_q <= mem_rdata;
          SEL_X:   x_q <= mem_rdata;
          default: y_q <= mem_rdata;
        endcase
      end
      if (dec_last) begin
        state_q <= ST_FIN;
        if (dec_push) begin
          p_q <= fin_p;
          d_q <= fin_d;
          a_q <= fin_a;
          x_q <= fin_x;
          y_q <= fin_y;
        end
      end else begin
        step_q <= step_q + 1'b1;
      end
    end else begin
      state_q <= ST_IDLE;
    end
  end

  assign out_pc = pc_q;
  assign out_p  = p_q;
  assign out_d  = d_q;
  assign out_a  = a_q;
  assign out_x  = x_q;
  assign out_y  = y_q;
  assign out_s  = s_q;

  // R2: every strobe lands in the stack page
  assert_page_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (mem_addr[PC_W-1:REG_W] == STACK_PAGE));

  // R2: a write is followed by a decremented pointer
  assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (s_q == $past(s_q) - 1'b1));

  // R2: a read is followed by an incremented pointer
  assert_pop_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (s_q == $past(s_q) + 1'b1));

  // R8: done is a single-cycle strobe
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: entry completes with the mask flag set and working registers cleared
  assert_enter_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_LOW_ENTER) |->
      (out_p[MFLAG_BIT] && out_a == '0 && out_y == '0 && out_d == '0));

  // R1: request pins cannot disturb a run in progress
  assert_busy_ignores_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && req_valid) |=> $stable(op_q));

  // R1: no strobe without a running sequence behind it
  assert_strobe_needs_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> !req_ready);
endmodule

// File: tb/irq_ctx_sequencer_test.sv
module irq_ctx_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [1:0]  req_op;
  logic [15:0] in_pc;
  logic [7:0]  in_p, in_d, in_a, in_x, in_y, in_s;
  logic        mem_we, mem_re, done;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] out_pc;
  logic [7:0]  out_p, out_d, out_a, out_x, out_y, out_s;

  always #5 clk = ~clk;

  irq_ctx_sequencer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .in_pc(in_pc), .in_p(in_p), .in_d(in_d), .in_a(in_a),
    .in_x(in_x), .in_y(in_y), .in_s(in_s), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .out_pc(out_pc), .out_p(out_p), .out_d(out_d),
    .out_a(out_a), .out_x(out_x), .out_y(out_y), .out_s(out_s)
  );

  logic [7:0] stack_mem [0:255];
  assign mem_rdata = stack_mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) stack_mem[mem_addr[7:0]] <= mem_wdata;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [7:0] last_s = 8'h00;

  typedef struct packed {
    logic [1:0]  op;
    logic        chain;
    logic [15:0] pc;
    logic [7:0]  p, d, a, x, y, s;
  } vec_t;

  // op 0 entry, 1 return, 2 prologue, 3 epilogue; chain = take S from previous result
  localparam vec_t VECS [0:7] = '{
    '{2'd0, 1'b0, 16'h1234, 8'h24, 8'h30, 8'h11, 8'h22, 8'h33, 8'hFF},
    '{2'd1, 1'b1, 16'h0000, 8'h00, 8'h55, 8'h66, 8'h77, 8'h88, 8'h00},
    '{2'd2, 1'b0, 16'hABCD, 8'h81, 8'h42, 8'h5A, 8'h6B, 8'h7C, 8'hF0},
    '{2'd3, 1'b1, 16'hABCD, 8'h81, 8'h00, 8'h00, 8'h42, 8'h00, 8'h00},
    '{2'd0, 1'b0, 16'hFEDC, 8'hFF, 8'h9A, 8'hBC, 8'hDE, 8'hF1, 8'h80},
    '{2'd2, 1'b1, 16'h0200, 8'h34, 8'h07, 8'hC3, 8'h3C, 8'h99, 8'h00},
    '{2'd3, 1'b1, 16'h0200, 8'h34, 8'h00, 8'h00, 8'h07, 8'h00, 8'h00},
    '{2'd1, 1'b1, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_seq(input logic [1:0] op, input logic [15:0] pc,
                         input logic [7:0] p, d, a, x, y, s, input bit hold);
    logic [7:0] ea [6];
    logic [7:0] ed [6];
    logic [7:0] bt [6];
    int n;
    bit push;
    string tag, otag;
    logic [15:0] epc;
    logic [7:0] ep, edd, eaa, ex, ey, es;
    epc = pc; ep = p; edd = d; eaa = a; ex = x; ey = y;
    push = (op == 2'd0) || (op == 2'd2);
    n = (op[1]) ? 3 : 6;
    if (op == 2'd0) begin
      bt[0] = pc[15:8]; bt[1] = pc[7:0]; bt[2] = p; bt[3] = d; bt[4] = a; bt[5] = y;
      otag = "R4"; tag = "R3";
    end else begin
      bt[0] = a; bt[1] = x; bt[2] = y; bt[3] = 8'h00; bt[4] = 8'h00; bt[5] = 8'h00;
      otag = (op == 2'd1) ? "R5" : (op == 2'd2) ? "R6" : "R7";
      tag = otag;
    end
    for (int k = 0; k < n; k++) begin
      if (push) begin
        ea[k] = s - 8'(k);
        ed[k] = bt[k];
      end else begin
        ea[k] = s + 8'(k + 1);
        ed[k] = stack_mem[ea[k]];
      end
    end
    case (op)
      2'd0: begin es = s - 8'd6; eaa = 0; ey = 0; edd = 0; ep = p | 8'h20; end
      2'd1: begin es = s + 8'd6; ey = ed[0]; eaa = ed[1]; edd = ed[2]; ep = ed[3];
                  epc = {ed[5], ed[4]}; end
      2'd2: begin es = s - 8'd3; ex = d; eaa = 0; ey = 0; edd = 0; end
      default: begin es = s + 8'd3; edd = x; ey = ed[0]; ex = ed[1]; eaa = ed[2]; end
    endcase
    last_s = es;

    @(negedge clk);
    req_valid = 1'b1; req_op = op; in_pc = pc; in_p = p; in_d = d;
    in_a = a; in_x = x; in_y = y; in_s = s;
    chk("R1", "ready before request", {15'd0, req_ready}, 16'd1);
    @(posedge clk);
    #1;
    // inputs are sampled only at acceptance: scramble them now
    req_valid = hold; req_op = ~op; in_pc = ~pc; in_p = ~p; in_d = ~d;
    in_a = ~a; in_x = ~x; in_y = ~y; in_s = ~s;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk("R8", "write strobe", {15'd0, mem_we}, {15'd0, push});
      chk("R8", "read strobe", {15'd0, mem_re}, {15'd0, ~push});
      chk("R2", "stack address", mem_addr, {8'h01, ea[k]});
      if (push) chk(tag, "pushed byte", {8'd0, mem_wdata}, {8'd0, ed[k]});
      if (hold) chk("R1", "ready low while busy", {15'd0, req_ready}, 16'd0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "done after last access", {15'd0, done}, 16'd1);
    chk(otag, "out_pc", out_pc, epc);
    chk(otag, "out_p", {8'd0, out_p}, {8'd0, ep});
    chk(otag, "out_d", {8'd0, out_d}, {8'd0, edd});
    chk(otag, "out_a", {8'd0, out_a}, {8'd0, eaa});
    chk(otag, "out_x", {8'd0, out_x}, {8'd0, ex});
    chk(otag, "out_y", {8'd0, out_y}, {8'd0, ey});
    chk(otag, "out_s", {8'd0, out_s}, {8'd0, es});
    @(negedge clk);
    chk("R8", "done lasts one cycle", {15'd0, done}, 16'd0);
    chk("R1", "no access after run", {14'd0, mem_we, mem_re}, 16'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) stack_mem[i] = 8'(i * 7 + 3);
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; in_pc = 16'hFFFF;
    in_p = 8'hFF; in_d = 8'hFF; in_a = 8'hFF; in_x = 8'hFF; in_y = 8'hFF; in_s = 8'hFF;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "ready in reset", {15'd0, req_ready}, 16'd1);
    chk("R9", "done in reset", {15'd0, done}, 16'd0);
    chk("R9", "strobes in reset", {14'd0, mem_we, mem_re}, 16'd0);
    chk("R9", "out_pc in reset", out_pc, 16'd0);
    chk("R9", "regs in reset", {8'd0, out_p | out_d | out_a | out_x | out_y | out_s}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      run_seq(VECS[v].op, VECS[v].pc, VECS[v].p, VECS[v].d, VECS[v].a,
              VECS[v].x, VECS[v].y, VECS[v].chain ? last_s : VECS[v].s, 1'b0);
    end

    // R10: entry near the bottom of the pointer range, then return across the wrap
    run_seq(2'd0, 16'h4321, 8'h01, 8'h10, 8'h20, 8'h30, 8'h40, 8'h02, 1'b0);
    chk("R10", "pointer wrapped", {8'd0, last_s}, 16'h00FC);
    run_seq(2'd1, 16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, last_s, 1'b0);
    chk("R10", "restored pc across wrap", out_pc, 16'h4321);

    // R10: epilogue pops across 0xFF to 0x00
    stack_mem[8'hFF] = 8'hA1; stack_mem[8'h00] = 8'hB2; stack_mem[8'h01] = 8'hC3;
    run_seq(2'd3, 16'h0777, 8'h04, 8'h00, 8'h00, 8'h5E, 8'h00, 8'hFE, 1'b0);

    // R1: request held high through a run is not taken
    run_seq(2'd2, 16'h0999, 8'h10, 8'h66, 8'h01, 8'h02, 8'h03, 8'hC0, 1'b1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule